// File: doc/BRIEF.md
# ALU Operand-Wait Station

This block parks dispatched arithmetic and logic operations until both of their source values are known, then hands them one at a time to an ALU. Each held operation carries two operand slots, and each slot keeps a 32-bit value, the tag of the producer it waits for, and a ready bit. An operation dispatched as an immediate form keeps its immediate in the second slot, and that slot is ready from the start.

A result broadcast (enable, tag, value) is compared against every waiting slot. Each slot whose tag matches takes the value and becomes ready. That includes the slots of an operation being dispatched in the same cycle. Held operations are kept in arrival order. In every cycle, the oldest one with both slots ready is presented on the issue outputs, and it leaves the buffer at the next clock edge. A full flag tells the dispatcher that no slot is free. A flush input empties the buffer.

Top module: `alu_wait_station`

## Requirements
- R1: After reset, and in the cycle after a flush, the buffer is empty: `iss_vld` is 0 and `full` is 0.
- R2: An operation is stored only in a cycle with `disp_en` high, `full` low and `flush` low. Otherwise, the dispatch inputs leave the contents unchanged.
- R3: A held operation is issued only when both of its operand slots are ready, where a ready bit of 1 means the value is present and 0 means it is pending. `iss_vld` is 1 exactly when some held operation is ready.
- R4: With `bc_en` high, every held slot that is pending and whose tag equals `bc_tag` captures `bc_val` and becomes ready. A slot that is already ready keeps its value.
- R5: A broadcast in the same cycle as a dispatch also wakes the pending slots of the incoming operation with the broadcast value.
- R6: With `disp_itype` high, slot 2 stores `disp_imm` and is ready, whatever the second source inputs say. With `disp_itype` low, slot 2 stores the second source value, tag and ready bit.
- R7: Among ready operations, the one dispatched earliest is issued. Its slot 1 value, slot 2 value, 7-bit opcode/func7 field, 3-bit func3 field and 5-bit destination tag appear on the issue outputs.
- R8: The issued operation is freed at the clock edge ending the cycle in which it is shown. A dispatch accepted in that same cycle takes the next free slot in age order.
- R9: `full` is 1 exactly when all DEPTH (default 4) slots are held. A dispatch while `full` is 1 is dropped, even if an issue frees a slot in that cycle.
- R10: `flush` high empties the buffer at the next edge, and a dispatch in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the buffer |
| disp_en | input | 1 | Dispatch an operation |
| disp_itype | input | 1 | Immediate form: slot 2 takes disp_imm |
| disp_a_val | input | 32 | Source 1 value |
| disp_a_tag | input | 5 | Source 1 producer tag |
| disp_a_rdy | input | 1 | Source 1 value present |
| disp_b_val | input | 32 | Source 2 value |
| disp_b_tag | input | 5 | Source 2 producer tag |
| disp_b_rdy | input | 1 | Source 2 value present |
| disp_imm | input | 32 | Extended immediate |
| disp_op7 | input | 7 | Opcode/func7 field |
| disp_f3 | input | 3 | func3 field |
| disp_dst | input | 5 | Destination tag |
| bc_en | input | 1 | Result broadcast valid |
| bc_tag | input | 5 | Broadcast tag |
| bc_val | input | 32 | Broadcast value |
| iss_vld | output | 1 | An operation is issued this cycle |
| iss_a | output | 32 | Issued slot 1 value |
| iss_b | output | 32 | Issued slot 2 value |
| iss_op7 | output | 7 | Issued opcode/func7 |
| iss_f3 | output | 3 | Issued func3 |
| iss_dst | output | 5 | Issued destination tag |
| full | output | 1 | No free slot |

## Verification
Three actions can share a single cycle: a broadcast waking held slots, the removal of the issued operation, and the acceptance of a new dispatch, which the broadcast may also wake. The bench uses only four tag values and frequent broadcasts, so all three land together often. These collisions are provoked both in directed sequences and in a long pseudo-random run. Each cycle, the issue outputs and the full flag are compared against an ordered-list model kept in the bench.

// File: rtl/alu_wait_station.sv
module alu_wait_station #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int TW    = 5,
  parameter int OPW   = 7,
  parameter int FW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           disp_en,
  input  logic           disp_itype,
  input  logic [DW-1:0]  disp_a_val,
  input  logic [TW-1:0]  disp_a_tag,
  input  logic           disp_a_rdy,
  input  logic [DW-1:0]  disp_b_val,
  input  logic [TW-1:0]  disp_b_tag,
  input  logic           disp_b_rdy,
  input  logic [DW-1:0]  disp_imm,
  input  logic [OPW-1:0] disp_op7,
  input  logic [FW-1:0]  disp_f3,
  input  logic [TW-1:0]  disp_dst,
  input  logic           bc_en,
  input  logic [TW-1:0]  bc_tag,
  input  logic [DW-1:0]  bc_val,
  output logic           iss_vld,
  output logic [DW-1:0]  iss_a,
  output logic [DW-1:0]  iss_b,
  output logic [OPW-1:0] iss_op7,
  output logic [FW-1:0]  iss_f3,
  output logic [TW-1:0]  iss_dst,
  output logic           full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]  a_val [DEPTH];
  logic [DW-1:0]  b_val [DEPTH];
  logic [TW-1:0]  a_tag [DEPTH];
  logic [TW-1:0]  b_tag [DEPTH];
  logic [TW-1:0]  dst   [DEPTH];
  logic [OPW-1:0] op7   [DEPTH];
  logic [FW-1:0]  f3    [DEPTH];
  logic [DEPTH-1:0] a_rdy, b_rdy;
  logic [CW-1:0]  cnt;

  logic [DW-1:0]  wa_val [DEPTH];
  logic [DW-1:0]  wb_val [DEPTH];
  logic [DEPTH-1:0] wa_rdy, wb_rdy, go;
  logic [IW-1:0]  pick;

  logic [DW-1:0]  n_a_val [DEPTH];
  logic [DW-1:0]  n_b_val [DEPTH];
  logic [TW-1:0]  n_a_tag [DEPTH];
  logic [TW-1:0]  n_b_tag [DEPTH];
  logic [TW-1:0]  n_dst   [DEPTH];
  logic [OPW-1:0] n_op7   [DEPTH];
  logic [FW-1:0]  n_f3    [DEPTH];
  logic [DEPTH-1:0] n_a_rdy, n_b_rdy;
  logic [CW-1:0]  n_cnt, base;

  logic           in_a_hit, in_b_hit, accept;
  logic [DW-1:0]  in_a_val, in_b_val;
  logic           in_a_rdy, in_b_rdy;

  assign full   = (cnt == CW'(DEPTH));
  assign accept = disp_en && !full && !flush;

  assign in_a_hit = bc_en && !disp_a_rdy && (disp_a_tag == bc_tag);
  assign in_b_hit = bc_en && !disp_b_rdy && (disp_b_tag == bc_tag);
  assign in_a_val = in_a_hit ? bc_val : disp_a_val;
  assign in_a_rdy = disp_a_rdy | in_a_hit;
  assign in_b_val = disp_itype ? disp_imm : (in_b_hit ? bc_val : disp_b_val);
  assign in_b_rdy = disp_itype | disp_b_rdy | in_b_hit;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      go[i]     = (CW'(i) < cnt) && a_rdy[i] && b_rdy[i];
      wa_rdy[i] = a_rdy[i] | (bc_en && a_tag[i] == bc_tag);
      wb_rdy[i] = b_rdy[i] | (bc_en && b_tag[i] == bc_tag);
      wa_val[i] = (bc_en && !a_rdy[i] && a_tag[i] == bc_tag) ? bc_val : a_val[i];
      wb_val[i] = (bc_en && !b_rdy[i] && b_tag[i] == bc_tag) ? bc_val : b_val[i];
    end
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (go[i]) pick = IW'(i);
  end

  assign iss_vld = |go;
  assign iss_a   = a_val[pick];
  assign iss_b   = b_val[pick];
  assign iss_op7 = op7[pick];
  assign iss_f3  = f3[pick];
  assign iss_dst = dst[pick];

  assign base  = cnt - CW'(iss_vld);
  assign n_cnt = flush ? '0 : base + CW'(accept);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = i;
      if (iss_vld && i >= int'(pick) && i < DEPTH - 1) s = i + 1;
      n_a_val[i] = wa_val[s];  n_a_tag[i] = a_tag[s];  n_a_rdy[i] = wa_rdy[s];
      n_b_val[i] = wb_val[s];  n_b_tag[i] = b_tag[s];  n_b_rdy[i] = wb_rdy[s];
      n_dst[i]   = dst[s];     n_op7[i]   = op7[s];    n_f3[i]    = f3[s];
      if (accept && CW'(i) == base) begin
        n_a_val[i] = in_a_val;  n_a_tag[i] = disp_a_tag;  n_a_rdy[i] = in_a_rdy;
        n_b_val[i] = in_b_val;  n_b_tag[i] = disp_b_tag;  n_b_rdy[i] = in_b_rdy;
        n_dst[i]   = disp_dst;  n_op7[i]   = disp_op7;    n_f3[i]    = disp_f3;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      a_rdy <= '0;
      b_rdy <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        a_val[i] <= '0; b_val[i] <= '0; a_tag[i] <= '0; b_tag[i] <= '0;
        dst[i] <= '0; op7[i] <= '0; f3[i] <= '0;
      end
    end else begin
      cnt   <= n_cnt;
      a_rdy <= n_a_rdy;
      b_rdy <= n_b_rdy;
      for (int i = 0; i < DEPTH; i++) begin
        a_val[i] <= n_a_val[i]; b_val[i] <= n_b_val[i];
        a_tag[i] <= n_a_tag[i]; b_tag[i] <= n_b_tag[i];
        dst[i] <= n_dst[i]; op7[i] <= n_op7[i]; f3[i] <= n_f3[i];
      end
    end
  end

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!iss_vld && !full));

  // R9
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !iss_vld && !flush) |=> full);

  // R8
  issue_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !disp_en) |=> !full);

  // R3
  no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_vld && !disp_en && !bc_en) |=> !iss_vld);

  // R2
  idle_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && !iss_vld && !flush) |=> $stable(full));
endmodule

// File: tb/alu_wait_station_test.sv
module alu_wait_station_test;
  logic clk = 0, rst_n = 0;
  logic flush = 0, disp_en = 0, disp_itype = 0, disp_a_rdy = 0, disp_b_rdy = 0, bc_en = 0;
  logic [31:0] disp_a_val = 0, disp_b_val = 0, disp_imm = 0, bc_val = 0;
  logic [4:0]  disp_a_tag = 0, disp_b_tag = 0, disp_dst = 0, bc_tag = 0;
  logic [6:0]  disp_op7 = 0;
  logic [2:0]  disp_f3 = 0;
  logic iss_vld, full;
  logic [31:0] iss_a, iss_b;
  logic [6:0]  iss_op7;
  logic [2:0]  iss_f3;
  logic [4:0]  iss_dst;

  int total = 0, bad = 0;

  logic [31:0] ma [4], mb [4];
  logic [4:0]  mat [4], mbt [4], md [4];
  logic        mar [4], mbr [4];
  logic [6:0]  mo [4];
  logic [2:0]  mf [4];
  int mc = 0;

  always #10 clk = ~clk;

  alu_wait_station uut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Called at a negedge with inputs already applied; returns at the next negedge.
  task automatic cyc(input string req);
    int idx;
    logic acc;
    logic [31:0] na, nb;
    logic nar, nbr;
    #1;
    idx = -1;
    for (int i = 0; i < mc; i++)
      if (idx < 0 && mar[i] && mbr[i]) idx = i;
    chk({req, " R3"}, "iss_vld", 32'(iss_vld), 32'(idx >= 0));
    chk({req, " R9"}, "full", 32'(full), 32'(mc == 4));
    if (idx >= 0) begin
      chk({req, " R4"}, "iss_a", iss_a, ma[idx]);
      chk({req, " R6"}, "iss_b", iss_b, mb[idx]);
      chk({req, " R7"}, "iss_op7", 32'(iss_op7), 32'(mo[idx]));
      chk({req, " R7"}, "iss_f3", 32'(iss_f3), 32'(mf[idx]));
      chk({req, " R7"}, "iss_dst", 32'(iss_dst), 32'(md[idx]));
    end
    for (int i = 0; i < mc; i++) begin
      if (bc_en && !mar[i] && mat[i] == bc_tag) begin ma[i] = bc_val; mar[i] = 1; end
      if (bc_en && !mbr[i] && mbt[i] == bc_tag) begin mb[i] = bc_val; mbr[i] = 1; end
    end
    na = disp_a_val; nar = disp_a_rdy;
    if (bc_en && !nar && disp_a_tag == bc_tag) begin na = bc_val; nar = 1; end
    nb = disp_b_val; nbr = disp_b_rdy;
    if (bc_en && !nbr && disp_b_tag == bc_tag) begin nb = bc_val; nbr = 1; end
    if (disp_itype) begin nb = disp_imm; nbr = 1; end
    acc = disp_en && mc < 4 && !flush;
    if (idx >= 0) begin
      for (int j = idx; j < mc - 1; j++) begin
        ma[j] = ma[j+1]; mb[j] = mb[j+1]; mat[j] = mat[j+1]; mbt[j] = mbt[j+1];
        mar[j] = mar[j+1]; mbr[j] = mbr[j+1]; mo[j] = mo[j+1]; mf[j] = mf[j+1]; md[j] = md[j+1];
      end
      mc--;
    end
    if (flush) mc = 0;
    else if (acc) begin
      ma[mc] = na; mar[mc] = nar; mat[mc] = disp_a_tag;
      mb[mc] = nb; mbr[mc] = nbr; mbt[mc] = disp_b_tag;
      mo[mc] = disp_op7; mf[mc] = disp_f3; md[mc] = disp_dst;
      mc++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    flush = 0; disp_en = 0; bc_en = 0; disp_itype = 0;
  endtask

  task automatic put(input logic [31:0] a, input logic [4:0] at, input logic ar,
                     input logic [31:0] b, input logic [4:0] bt, input logic br,
                     input logic it, input logic [4:0] d);
    disp_en = 1; disp_a_val = a; disp_a_tag = at; disp_a_rdy = ar;
    disp_b_val = b; disp_b_tag = bt; disp_b_rdy = br; disp_itype = it;
    disp_imm = 32'h1000 + 32'(d); disp_op7 = 7'(d * 3); disp_f3 = 3'(d); disp_dst = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "iss_vld", 32'(iss_vld), 0);
    chk("R1", "full", 32'(full), 0);
    @(negedge clk);

    // R2: dispatch inputs toggling with disp_en low store nothing
    quiet(); put(32'h11, 0, 1, 32'h22, 0, 1, 0, 1); disp_en = 0; cyc("R2");
    quiet(); cyc("R2");

    // R5: pending source woken by broadcast in its dispatch cycle
    put(32'h0, 5'd2, 0, 32'h33, 0, 1, 0, 5'd4); bc_en = 1; bc_tag = 5'd2; bc_val = 32'hCAFE; cyc("R5");
    quiet(); cyc("R5");

    // R6: immediate form ignores a pending second source
    put(32'h7, 0, 1, 32'h0, 5'd3, 0, 1, 5'd6); cyc("R6");
    quiet(); cyc("R6");

    // R4 / R7: younger ready operation bypasses an older waiting one
    put(32'h0, 5'd1, 0, 32'h5, 0, 1, 0, 5'd8); cyc("R7");
    put(32'h9, 0, 1, 32'hA, 0, 1, 0, 5'd9); cyc("R7");
    quiet(); bc_en = 1; bc_tag = 5'd1; bc_val = 32'hBEEF; cyc("R4");
    quiet(); cyc("R4"); cyc("R4");

    // R9 / R8: fill, drop a dispatch while full, then refill behind an issue
    for (int k = 0; k < 4; k++) begin
      put(32'(k), 5'd3, 0, 32'(k + 40), 0, 1, 0, 5'(k + 10)); cyc("R9");
    end
    put(32'h55, 0, 1, 32'h66, 0, 1, 0, 5'd20); cyc("R9");
    quiet(); bc_en = 1; bc_tag = 5'd3; bc_val = 32'h77; cyc("R8");
    put(32'h88, 0, 1, 32'h99, 0, 1, 0, 5'd21); cyc("R8");
    put(32'hAA, 0, 1, 32'hBB, 0, 1, 1, 5'd22); cyc("R8");

    // R10: flush with a dispatch in the same cycle
    put(32'h1, 0, 1, 32'h2, 0, 1, 0, 5'd23); flush = 1; cyc("R10");
    quiet(); cyc("R10");

    // Sweep: small tag space so wakeups, issues and dispatches collide
    for (int n = 0; n < 4000; n++) begin
      flush      = ($urandom % 80) == 0;
      disp_en    = ($urandom % 2) == 0;
      disp_itype = ($urandom % 3) == 0;
      disp_a_val = $urandom; disp_b_val = $urandom; disp_imm = $urandom;
      disp_a_tag = 5'($urandom % 4); disp_b_tag = 5'($urandom % 4);
      disp_a_rdy = ($urandom % 5) < 2; disp_b_rdy = ($urandom % 5) < 2;
      disp_op7 = 7'($urandom); disp_f3 = 3'($urandom); disp_dst = 5'($urandom);
      bc_en = ($urandom % 2) == 0; bc_tag = 5'($urandom % 4); bc_val = $urandom;
      cyc("R2 R5 R8");
    end
    quiet();
    cyc("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule